// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets software on a register bus reach PHY management registers over a two-wire MDIO bus. Software loads a 16-bit address value and a 16-bit write value into their registers. It then writes a command word that selects the frame type, the opcode, the port and the device or register number, with the go bit set. The block divides the system clock down to MDC. It shifts out a 64-bit management frame made of a 32-bit preamble of ones, the start code, the opcode, two 5-bit address fields, a turnaround and 16 data bits. For reads it releases the data line at the turnaround and captures the PHY's response. The go bit stays set while the frame runs and drops when the frame ends, so software polls it before it issues the next command.

An extended-addressing (Clause 45) access takes two commands. The first is an address frame that carries the address register. The second is a separate write, read or read-with-increment frame. A Clause 22 access takes a single command. A read that gets no answer from the PHY sets a failure flag in the status register. The read value is valid only while that flag is clear.

Top module: `mdio_mst_top`

## Requirements
- R1: After reset every readable register returns 0, MDC is low and the data-line output enable is low.
- R2: Offset 0x4 holds the address value and offset 0x8 holds the write value. Each keeps the low 16 bits of a write and reads back 0 in bits 31:16. Writes to the read-data offset 0xC and the status offset 0x10 have no effect.
- R3: The command word at offset 0x0 uses bits 4:0 for the device or register number, bits 9:5 for the port, bits 11:10 for the opcode, bits 13:12 for the start-code select and bit 14 for go. A command write made while a frame is running is ignored: the stored fields do not change and no second frame follows.
- R4: Command bit 14 reads 1 from the cycle after an accepted go until the frame completes, then reads 0. The output enable is low whenever no frame is running.
- R5: Every frame sends, MSB first, 32 ones, then two start-code bits equal to command bits 13:12 (select 0 gives 00, select 1 gives 01), then the opcode, the port, the device or register number, and then, for non-read frames, the turnaround 10 and 16 data bits.
- R6: When the select is 0 and the opcode is 0 (address frame), the data field carries the address register. In every other non-read frame it carries the write value.
- R7: A frame is a read when the select is 1 with opcode 2, or the select is 0 with opcode 2 or 3. For a read the output enable is low from frame bit 46 through bit 63, and the 16 bits sampled at the last 16 MDC rising edges are loaded, MSB first, into offset 0xC.
- R8: Status bit 0 is set by a read whose second turnaround bit (frame bit 47) is sampled high, and cleared by a read that samples it low. Non-read frames leave it unchanged.
- R9: MDC idles low. It has a period of 2*MDC_HALF system clocks with exactly 64 rising edges per frame. The data output changes only on the cycle in which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | BUS_W | Register write value |
| reg_rdata | output | BUS_W | Read value of the register at reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable, low releases the line |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The bench aims at the turnaround of read frames. A design that kept driving through bit 46 would collide with the PHY. A design that sampled the wrong edge would set or clear the failure flag on a data bit. The bench lets one read succeed and lets another find only the pull-up, then checks that a later write frame leaves the flag alone. It fires a second command in the middle of a frame and counts MDC edges. A block that re-armed on that write would show altered fields, a changed frame or more than 64 rising edges. It also compares an address frame with a write frame to catch a data field taken from the wrong register.

// File: rtl/mdio_mst_pkg.sv
package mdio_mst_pkg;

    localparam int FRAME_LEN  = 64;
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;
    localparam int FIELD_W    = 16;

    localparam logic [4:0] OFS_CMD   = 5'h00;
    localparam logic [4:0] OFS_ADR   = 5'h04;
    localparam logic [4:0] OFS_WDAT  = 5'h08;
    localparam logic [4:0] OFS_RDAT  = 5'h0C;
    localparam logic [4:0] OFS_STAT  = 5'h10;

    localparam logic [1:0] SEL_EXT   = 2'd0;
    localparam logic [1:0] SEL_BASIC = 2'd1;
    localparam logic [1:0] OP_BASIC_RD = 2'd2;
    localparam logic [1:0] OP_EXT_ADR  = 2'd0;
    localparam logic [1:0] OP_EXT_RDI  = 2'd2;
    localparam logic [1:0] OP_EXT_RD   = 2'd3;

    typedef struct packed {
        logic       go;
        logic [1:0] sel;
        logic [1:0] op;
        logic [4:0] port;
        logic [4:0] dev;
    } cmd_t;

    function automatic logic op_is_read(cmd_t c);
        if (c.sel == SEL_EXT)
            return (c.op == OP_EXT_RDI) || (c.op == OP_EXT_RD);
        return c.op == OP_BASIC_RD;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int MDC_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = $clog2(MDC_HALF) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t q, d;
    logic tick;

    always_comb begin
        d        = q;
        tick     = run && (q.cnt == CW'(MDC_HALF - 1));
        rise_stb = tick && !q.mdc;
        fall_stb = tick && q.mdc;
        if (!run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc); // R9

    AST_MDC_EDGE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(mdc)) |-> $past(tick)); // R9

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mst_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  cmd_t               cmd,
    input  logic [FIELD_W-1:0] adr_val,
    input  logic [FIELD_W-1:0] wr_val,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               busy,
    output logic               is_rd,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic [FIELD_W-1:0] rd_val,
    output logic               rd_fail
);
    localparam int IW = $clog2(FRAME_LEN);

    typedef struct packed {
        logic                 busy;
        logic                 rd;
        logic [FRAME_LEN-1:0] sh;
        logic [IW-1:0]        idx;
        logic                 oe;
        logic [FIELD_W-1:0]   rsh;
        logic                 fail;
    } seq_t;

    seq_t q, d;
    logic               new_rd;
    logic [FIELD_W-1:0] payload;
    logic [IW-1:0]      nidx;

    always_comb begin
        d       = q;
        done    = 1'b0;
        new_rd  = op_is_read(cmd);
        payload = ((cmd.sel == SEL_EXT) && (cmd.op == OP_EXT_ADR)) ? adr_val : wr_val;
        nidx    = q.idx + IW'(1);
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.rd   = new_rd;
                d.idx  = '0;
                d.oe   = 1'b1;
                d.fail = 1'b0;
                d.sh   = {32'hFFFF_FFFF, cmd.sel, cmd.op, cmd.port, cmd.dev,
                          new_rd ? 2'b11 : 2'b10,
                          new_rd ? {FIELD_W{1'b1}} : payload};
            end
        end else begin
            if (rise_stb) begin
                if (q.idx == IW'(TA_SECOND))
                    d.fail = mdio_i;
                if (q.idx >= IW'(DATA_FIRST))
                    d.rsh = {q.rsh[FIELD_W-2:0], mdio_i};
            end
            if (fall_stb) begin
                if (q.idx == IW'(FRAME_LEN - 1)) begin
                    d.busy = 1'b0;
                    d.oe   = 1'b0;
                    d.sh   = '0;
                    done   = 1'b1;
                end else begin
                    d.idx = nidx;
                    d.sh  = {q.sh[FRAME_LEN-2:0], 1'b0};
                    d.oe  = !(q.rd && (nidx >= IW'(TA_FIRST)));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign is_rd   = q.rd;
    assign mdio_o  = q.sh[FRAME_LEN-1];
    assign mdio_oe = q.oe;
    assign rd_val  = q.rsh;
    assign rd_fail = q.fail;

    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_stb)); // R9

    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb)); // R9

    AST_RELEASE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rd && !mdio_oe) |=> !mdio_oe); // R7

endmodule

// File: rtl/mdio_mst_top.sv
module mdio_mst_top
    import mdio_mst_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int BUS_W    = 32,
    parameter int MDC_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int CMD_W = $bits(cmd_t);

    typedef struct packed {
        logic [CMD_W-2:0]   cmd;
        logic [FIELD_W-1:0] adr;
        logic [FIELD_W-1:0] wdat;
        logic [FIELD_W-1:0] rdat;
        logic               fail;
    } regs_t;

    regs_t q, d;
    logic               busy, is_rd, done, rd_fail, rise_stb, fall_stb, start;
    logic [FIELD_W-1:0] rd_val;
    logic [4:0]         ofs;
    cmd_t               wcmd;

    assign ofs  = 5'(reg_addr);
    assign wcmd = cmd_t'(reg_wdata[CMD_W-1:0]);

    always_comb begin
        d     = q;
        start = 1'b0;
        if (reg_we && !busy) begin
            unique case (ofs)
                OFS_CMD: begin
                    d.cmd = reg_wdata[CMD_W-2:0];
                    start = wcmd.go;
                end
                OFS_ADR:  d.adr  = reg_wdata[FIELD_W-1:0];
                OFS_WDAT: d.wdat = reg_wdata[FIELD_W-1:0];
                default: ;
            endcase
        end else if (reg_we) begin
            unique case (ofs)
                OFS_ADR:  d.adr  = reg_wdata[FIELD_W-1:0];
                OFS_WDAT: d.wdat = reg_wdata[FIELD_W-1:0];
                default: ;
            endcase
        end
        if (done && is_rd) begin
            d.rdat = rd_val;
            d.fail = rd_fail;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (ofs)
            OFS_CMD:  reg_rdata[CMD_W-1:0]   = {busy, q.cmd};
            OFS_ADR:  reg_rdata[FIELD_W-1:0] = q.adr;
            OFS_WDAT: reg_rdata[FIELD_W-1:0] = q.wdat;
            OFS_RDAT: reg_rdata[FIELD_W-1:0] = q.rdat;
            OFS_STAT: reg_rdata[0]           = q.fail;
            default: ;
        endcase
    end

    mdio_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (wcmd),
        .adr_val  (q.adr),
        .wr_val   (q.wdat),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .is_rd    (is_rd),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_val   (rd_val),
        .rd_fail  (rd_fail)
    );

    AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && ofs == OFS_CMD) |=> $stable(q.cmd)); // R3

    AST_GO_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && ofs == OFS_CMD && reg_wdata[CMD_W-1])); // R4

    AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R4

    AST_FAIL_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.fail) |-> $past(done && is_rd)); // R8

endmodule

// File: tb/mdio_mst_top_tb_top.sv
module mdio_mst_top_tb_top;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_line;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int last_rise = 0;
    int per_err = 0;
    logic        phy_en = 1'b0;
    logic [15:0] phy_data = '0;
    logic        cap_bit [64];
    logic        cap_oe  [64];

    always #10 clk = !clk;

    mdio_mst_top #(.ADDR_W(5), .BUS_W(32), .MDC_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // PHY model: pull-up unless enabled; answers TA low then data MSB first
    always_comb begin
        if (mdio_oe) mdio_line = mdio_o;
        else if (phy_en && rise_cnt == 47) mdio_line = 1'b0;
        else if (phy_en && rise_cnt >= 48 && rise_cnt < 64) mdio_line = phy_data[63 - rise_cnt];
        else mdio_line = 1'b1;
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_bit[rise_cnt] = mdio_line;
            cap_oe[rise_cnt]  = mdio_oe;
        end
        if (rise_cnt > 0 && (cyc - last_rise) != 2 * HALF) per_err++;
        last_rise = cyc;
        rise_cnt++;
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(150000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        summary();
    end

    task automatic wr(logic [4:0] a, logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] cmdw(logic [1:0] sel, logic [1:0] op, logic [4:0] p, logic [4:0] dv);
        return {17'd0, 1'b1, sel, op, p, dv};
    endfunction

    task automatic go(logic [31:0] c);
        rise_cnt = 0; per_err = 0;
        wr(5'h00, c);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(5'h00, v);
            if (!v[14]) return;
        end
        chk("R4 frame end timeout", 1, 0);
    endtask

    function automatic logic [63:0] cap_vec();
        logic [63:0] v;
        for (int k = 0; k < 64; k++) v[63 - k] = cap_bit[k];
        return v;
    endfunction

    function automatic logic [63:0] oe_vec();
        logic [63:0] v;
        for (int k = 0; k < 64; k++) v[63 - k] = cap_oe[k];
        return v;
    endfunction

    function automatic logic [63:0] exp_frame(logic [1:0] sel, logic [1:0] op, logic [4:0] p,
                                              logic [4:0] dv, logic [15:0] data);
        return {32'hFFFF_FFFF, sel, op, p, dv, 2'b10, data};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); chk("R1 cmd reset", v, 0);
        rd(5'h04, v); chk("R1 addr reset", v, 0);
        rd(5'h0C, v); chk("R1 rdata reset", v, 0);
        rd(5'h10, v); chk("R1 status reset", v, 0);
        chk("R1 mdc/oe reset", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(5'h04, 32'hDEAD_1234); rd(5'h04, v); chk("R2 addr low16", v, 32'h1234);
        wr(5'h08, 32'hBEEF_5A0F); rd(5'h08, v); chk("R2 wdata low16", v, 32'h5A0F);
        wr(5'h0C, 32'h0000_7777); rd(5'h0C, v); chk("R2 rdata not writable", v, 0);
        wr(5'h10, 32'h1); rd(5'h10, v); chk("R2 status not writable", v, 0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        wr(5'h08, 32'h0000_C3A5);
        go(cmdw(2'd1, 2'd1, 5'h15, 5'h0A));
        rd(5'h00, v); chk("R4 go bit busy", v[14], 1);
        wait_idle();
        chk("R5 c22 write frame", cap_vec(), exp_frame(2'd1, 2'd1, 5'h15, 5'h0A, 16'hC3A5));
        chk("R6 c22 write uses wdata", cap_vec() & 64'hFFFF, 64'hC3A5);
        chk("R9 rising edges", rise_cnt, 64);
        chk("R9 mdc period", per_err, 0);
        chk("R4 oe low after", {mdc, mdio_oe}, 0);
        rd(5'h00, v); chk("R3 cmd fields kept", v, {17'd0, 1'b0, 2'd1, 2'd1, 5'h15, 5'h0A});
    endtask

    task automatic t_c45_addr_write();
        wr(5'h04, 32'h0000_8001);
        wr(5'h08, 32'h0000_00FF);
        go(cmdw(2'd0, 2'd0, 5'h03, 5'h1E));
        wait_idle();
        chk("R6 c45 address frame", cap_vec(), exp_frame(2'd0, 2'd0, 5'h03, 5'h1E, 16'h8001));
        go(cmdw(2'd0, 2'd1, 5'h03, 5'h1E));
        wait_idle();
        chk("R5 c45 write frame", cap_vec(), exp_frame(2'd0, 2'd1, 5'h03, 5'h1E, 16'h00FF));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(5'h08, 32'h0000_1111);
        go(cmdw(2'd1, 2'd1, 5'h01, 5'h02));
        repeat (20) @(negedge clk);
        wr(5'h00, cmdw(2'd0, 2'd3, 5'h1F, 5'h1F));
        rd(5'h00, v); chk("R3 cmd write ignored while busy", v, {17'd0, 1'b1, 2'd1, 2'd1, 5'h01, 5'h02});
        wait_idle();
        chk("R3 frame unchanged", cap_vec(), exp_frame(2'd1, 2'd1, 5'h01, 5'h02, 16'h1111));
        repeat (40) @(negedge clk);
        chk("R3 no second frame", rise_cnt, 64);
    endtask

    task automatic t_read(logic [1:0] sel, logic [1:0] op, logic en, logic [15:0] data,
                          logic exp_fail, string tag);
        logic [31:0] v;
        phy_en = en; phy_data = data;
        go(cmdw(sel, op, 5'h07, 5'h11));
        wait_idle();
        phy_en = 1'b0;
        chk({"R5 read header ", tag}, cap_vec() >> 18, exp_frame(sel, op, 5'h07, 5'h11, 0) >> 18);
        chk({"R7 oe released at TA ", tag}, oe_vec(), {{46{1'b1}}, 18'd0});
        rd(5'h10, v); chk({"R8 status ", tag}, v, {31'd0, exp_fail});
        if (!exp_fail) begin
            rd(5'h0C, v); chk({"R7 read data ", tag}, v, {16'd0, data});
        end
    endtask

    task automatic t_fail_sticky();
        logic [31:0] v;
        t_read(2'd0, 2'd3, 1'b0, 16'h0, 1'b1, "c45 no answer");
        wr(5'h08, 32'h0000_2222);
        go(cmdw(2'd1, 2'd1, 5'h02, 5'h03));
        wait_idle();
        rd(5'h10, v); chk("R8 write leaves status", v, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_c22_write();
        t_c45_addr_write();
        t_busy_ignore();
        t_read(2'd1, 2'd2, 1'b1, 16'hA5C3, 1'b0, "c22 ok");
        t_fail_sticky();
        t_read(2'd0, 2'd2, 1'b1, 16'h3C96, 1'b0, "c45 incr ok");
        summary();
    end
endmodule